// File: doc/BRIEF.md
# Eight-Way Tree Pseudo-LRU Replacement With Group Locking

This block holds the replacement history of one set-associative cache with eight ways per set and picks the way to evict when a line must be brought in. Each set keeps a binary tree of seven decision bits. Every accepted hit or fill on a way rewrites the bits along that way's path so that they point away from it. When a victim is requested, the tree is walked from the root, and any half of a subtree whose ways are all locked is skipped in favour of the other half.

Locking is configured as a bit mask over equal-sized groups of adjacent ways. A locked way keeps taking part in history updates on hits but is never offered as a victim. When every group is locked, the block raises a no-victim flag, and fills presented in that state are dropped. The default geometry (32 KB, 32-byte lines, 8 ways) gives 128 sets. Set index, access strobe and victim request share one index port. The victim is produced combinationally from the stored state, in the same cycle as the request.

Top module: `plru_lock_top`

## Requirements
- R1: After a synchronous active-low reset, all tree bits of every set are zero, so with no locks every set offers way 0 as its victim.
- R2: An accepted access (hit or fill) to way w rewrites each tree node on w's path so that it points to the half not holding w. With no locks, the next victim for that set is then never w.
- R3: A tree bit of 0 steers the victim walk toward the lower-numbered half of its subtree and 1 toward the upper half. The root is node 0 and the children of node n are 2n+1 (lower) and 2n+2 (upper). With no locks, the victim follows the bits from the root.
- R4: A locked way is never offered as a victim. When one half of a subtree is fully locked, the walk takes the other half whatever the stored bit says.
- R5: Bit g of `lock_grp` locks ways g*GS to g*GS+GS-1, where GS = WAYS/LOCK_GROUPS (2 by default).
- R6: When every group is locked and a victim is requested, `vict_none` is 1 and `vict_way` is 0.
- R7: A fill presented while every group is locked leaves the tree unchanged. A hit on a locked way still updates the tree.
- R8: While `vict_req` is 0, `vict_way` and `vict_none` are both 0.
- R9: An access changes only the tree of the set it addresses.
- R10: The victim in a cycle reflects the tree as it stood before any access made in that same cycle; that access takes effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_idx | input | SETW (7) | Set addressed by the access and the victim request |
| acc_vld | input | 1 | Access strobe (hit or fill) |
| acc_fill | input | 1 | 1 = the access is a fill, 0 = a hit |
| acc_way | input | WW (3) | Way touched by the access |
| vict_req | input | 1 | Victim request |
| lock_grp | input | LOCK_GROUPS (4) | Lock mask, one bit per group of ways |
| vict_way | output | WW (3) | Chosen victim way |
| vict_none | output | 1 | Every way is locked; no victim is available |

## Verification
The bench builds the block with 8 ways, 4 lock groups and only 4 sets. This keeps the tree shape and lock grouping of the real configuration while the set space stays small enough for sets to collide often. The bench sweeps all 16 lock masks. Under each mask it runs a pseudo-random stream of hits, fills and victim requests across all sets and compares every victim against a bench model built from per-level path arithmetic. This covers fully locked subtrees at each level, fills dropped while everything is locked, and hits on locked ways. Directed steps check reset, set isolation and same-cycle ordering.

// File: rtl/plru_pkg.sv
// Package: shared geometry helpers for the pseudo-LRU replacement block.
// Assumes way counts are powers of two.
package plru_pkg;
    // Number of sets for a given capacity, line size and associativity.
    function automatic int sets_of(input int cap_bytes, input int line_bytes, input int ways);
        return cap_bytes / (line_bytes * ways);
    endfunction
endpackage

// File: rtl/plru_state_mem.sv
// Module: per-set storage of tree pseudo-LRU bits.
// One combinational read port and one synchronous write port share the set
// address; synchronous active-low reset clears every set.
module plru_state_mem #(
    parameter int SETS  = 128,
    parameter int NODES = 7,
    localparam int SETW = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SETW-1:0]  set_idx,
    input  logic             wr_en,
    input  logic [NODES-1:0] wr_bits,
    output logic [NODES-1:0] rd_bits
);
    logic [NODES-1:0] mem [SETS];

    // Read the addressed set's tree bits (state before any same-cycle write).
    always_comb rd_bits = mem[set_idx];

    // Clear all sets on reset, otherwise write the updated tree of the addressed set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) mem[s] <= '0;
        end else if (wr_en) begin
            mem[set_idx] <= wr_bits;
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk) !rst_n |=> rd_bits == '0)
        else $error("tree bits not cleared after reset");
endmodule

// File: rtl/plru_touch_update.sv
// Module: computes the new tree bits after an access to one way.
// Each node on the accessed way's path is set to point to the other half.
module plru_touch_update #(
    parameter int WAYS  = 8,
    localparam int WW    = $clog2(WAYS),
    localparam int NODES = WAYS - 1
) (
    input  logic [NODES-1:0] cur_bits,
    input  logic [WW-1:0]    way,
    output logic [NODES-1:0] nxt_bits
);
    // Walk root to leaf, pointing each visited node away from the accessed way.
    always_comb begin
        int node;
        int base;
        int span;
        int half;
        nxt_bits = cur_bits;
        node = 0;
        base = 0;
        span = WAYS;
        for (int l = 0; l < WW; l++) begin
            half = span / 2;
            if (int'(way) < base + half) begin
                nxt_bits[node] = 1'b1;
                node = 2 * node + 1;
            end else begin
                nxt_bits[node] = 1'b0;
                node = 2 * node + 2;
                base = base + half;
            end
            span = half;
        end
    end
endmodule

// File: rtl/plru_victim_pick.sv
// Module: combinational victim selection from tree bits and a per-way lock mask.
// A fully locked half of a subtree forces the walk into the other half.
// Assumes the caller reports the all-locked case separately.
module plru_victim_pick #(
    parameter int WAYS  = 8,
    localparam int WW    = $clog2(WAYS),
    localparam int NODES = WAYS - 1
) (
    input  logic [NODES-1:0] bits,
    input  logic [WAYS-1:0]  lock_way,
    output logic [WW-1:0]    pick
);
    // Descend the tree, steering around halves whose ways are all locked.
    always_comb begin
        int node;
        int base;
        int span;
        int half;
        logic lo_full;
        logic hi_full;
        logic go_hi;
        node = 0;
        base = 0;
        span = WAYS;
        for (int l = 0; l < WW; l++) begin
            half = span / 2;
            lo_full = 1'b1;
            hi_full = 1'b1;
            for (int w = 0; w < WAYS; w++) begin
                if (w >= base && w < base + half && !lock_way[w]) lo_full = 1'b0;
                if (w >= base + half && w < base + span && !lock_way[w]) hi_full = 1'b0;
            end
            if (lo_full)      go_hi = 1'b1;
            else if (hi_full) go_hi = 1'b0;
            else              go_hi = bits[node];
            if (go_hi) begin
                base = base + half;
                node = 2 * node + 2;
            end else begin
                node = 2 * node + 1;
            end
            span = half;
        end
        pick = WW'(base);
    end
endmodule

// File: rtl/plru_lock_top.sv
// Module: eight-way tree pseudo-LRU replacement with way locking by groups.
// Expands the group lock mask to ways, picks a victim from the addressed set,
// and writes back the updated tree on each accepted hit or fill.
// Assumes WAYS and LOCK_GROUPS are powers of two with LOCK_GROUPS <= WAYS.
module plru_lock_top #(
    parameter int CAP_BYTES   = 32768,
    parameter int LINE_BYTES  = 32,
    parameter int WAYS        = 8,
    parameter int SETS        = plru_pkg::sets_of(CAP_BYTES, LINE_BYTES, WAYS),
    parameter int LOCK_GROUPS = 4,
    localparam int SETW  = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WW    = $clog2(WAYS),
    localparam int NODES = WAYS - 1,
    localparam int GS    = WAYS / LOCK_GROUPS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SETW-1:0]        set_idx,
    input  logic                   acc_vld,
    input  logic                   acc_fill,
    input  logic [WW-1:0]          acc_way,
    input  logic                   vict_req,
    input  logic [LOCK_GROUPS-1:0] lock_grp,
    output logic [WW-1:0]          vict_way,
    output logic                   vict_none
);
    logic [WAYS-1:0]  lock_way;
    logic             all_locked;
    logic [NODES-1:0] cur_bits;
    logic [NODES-1:0] nxt_bits;
    logic [WW-1:0]    pick;
    logic             accept;

    // Replicate each group lock bit across the ways it covers.
    for (genvar g = 0; g < LOCK_GROUPS; g++) begin : g_lock
        assign lock_way[g*GS +: GS] = {GS{lock_grp[g]}};
    end

    // Flag the case where no way can be chosen.
    always_comb all_locked = &lock_way;

    // Accept hits always; drop fills when every way is locked.
    always_comb accept = acc_vld && !(acc_fill && all_locked);

    plru_state_mem #(.SETS(SETS), .NODES(NODES)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_idx (set_idx),
        .wr_en   (accept),
        .wr_bits (nxt_bits),
        .rd_bits (cur_bits)
    );

    plru_touch_update #(.WAYS(WAYS)) u_upd (
        .cur_bits (cur_bits),
        .way      (acc_way),
        .nxt_bits (nxt_bits)
    );

    plru_victim_pick #(.WAYS(WAYS)) u_pick (
        .bits     (cur_bits),
        .lock_way (lock_way),
        .pick     (pick)
    );

    // Gate the victim outputs with the request.
    always_comb begin
        vict_none = vict_req && all_locked;
        vict_way  = (vict_req && !all_locked) ? pick : '0;
    end

    // R4
    victim_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vict_req && !vict_none |-> !lock_grp[int'(vict_way) / GS])
        else $error("locked way offered as victim");

    // R6
    none_all_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vict_none |-> (lock_grp == '1 && vict_way == '0))
        else $error("no-victim flag without full lock");

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vict_req |-> (vict_way == '0 && !vict_none))
        else $error("victim outputs active without request");

    // R2
    touched_not_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && lock_grp == '0) |=>
            ((vict_req && lock_grp == '0 && set_idx == $past(set_idx)) -> vict_way != $past(acc_way)))
        else $error("just-touched way chosen as victim");
endmodule

// File: tb/plru_lock_top_tb.sv
module plru_lock_top_tb;
    localparam int WAYS = 8;
    localparam int SETS = 4;
    localparam int GRPS = 4;
    localparam int GS   = WAYS / GRPS;
    localparam int LV   = 3;

    logic clk = 0;
    logic rst_n = 0;
    logic [1:0] set_idx = '0;
    logic acc_vld = 0, acc_fill = 0, vict_req = 0;
    logic [2:0] acc_way = '0;
    logic [GRPS-1:0] lock_grp = '0;
    logic [2:0] vict_way;
    logic vict_none;

    int n_chk = 0;
    int n_bad = 0;
    logic [6:0] mdl [SETS];
    logic [15:0] lfsr = 16'hACE1;

    plru_lock_top #(.WAYS(WAYS), .SETS(SETS), .LOCK_GROUPS(GRPS)) u_dut (
        .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .acc_vld(acc_vld),
        .acc_fill(acc_fill), .acc_way(acc_way), .vict_req(vict_req),
        .lock_grp(lock_grp), .vict_way(vict_way), .vict_none(vict_none)
    );

    always #5 clk = ~clk;

    function automatic logic is_locked(input int w, input logic [GRPS-1:0] m);
        return m[w / GS];
    endfunction

    // Node index at level l on the path of way w, and the branch w takes there.
    function automatic int node_of(input int w, input int l);
        return (1 << l) - 1 + (w >> (LV - l));
    endfunction

    // Whole subtree at level l holding prefix p fully locked?
    function automatic logic sub_locked(input int l, input int p, input logic [GRPS-1:0] m);
        int sz;
        sz = WAYS >> l;
        for (int w = p * sz; w < (p + 1) * sz; w++) if (!is_locked(w, m)) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int mdl_victim(input logic [6:0] t, input logic [GRPS-1:0] m);
        int p;
        logic d;
        p = 0;
        for (int l = 0; l < LV; l++) begin
            if (sub_locked(l + 1, 2 * p, m))          d = 1'b1;
            else if (sub_locked(l + 1, 2 * p + 1, m)) d = 1'b0;
            else                                      d = t[(1 << l) - 1 + p];
            p = 2 * p + int'(d);
        end
        return p;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Apply inputs after negedge, check comb outputs, then let the edge commit.
    task automatic step(input int s, input logic av, input logic af, input int w,
                        input logic vr, input string req);
        int ev;
        logic en;
        @(negedge clk);
        set_idx = 2'(s); acc_vld = av; acc_fill = af; acc_way = 3'(w); vict_req = vr;
        #1;
        en = vr && (lock_grp == '1);
        ev = (vr && !en) ? mdl_victim(mdl[s], lock_grp) : 0;
        check(vr ? (en ? "R6" : req) : "R8", int'(vict_way), ev);
        check(vr ? (en ? "R6" : req) : "R8", int'(vict_none), int'(en));
        if (av && !(af && lock_grp == '1))
            for (int l = 0; l < LV; l++)
                mdl[s][node_of(w, l)] = ~w[LV - 1 - l];
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int s = 0; s < SETS; s++) mdl[s] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        // R1: every set offers way 0 after reset
        for (int s = 0; s < SETS; s++) step(s, 0, 0, 0, 1, "R1");
        // R5: group 0 locks ways 0..1 -> way 2; group 1 locks ways 2..3 -> way 0
        @(negedge clk) lock_grp = 4'b0001; #1 vict_req = 1; set_idx = 0; #1;
        check("R5", int'(vict_way), 2);
        lock_grp = 4'b0010; #1;
        check("R5", int'(vict_way), 0);
        lock_grp = '0;
        // R9: touching set 1 leaves set 0 untouched; R2/R3: set 1 now picks way 4
        step(1, 1, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 1, "R9");
        step(1, 0, 0, 0, 1, "R2");
        // R10: same-cycle access does not alter this cycle's victim
        step(1, 1, 1, 4, 1, "R10");
        step(1, 0, 0, 0, 1, "R3");
        // R7: fill with everything locked is dropped; hit still updates
        lock_grp = 4'b1111;
        step(2, 1, 1, 5, 1, "R7");
        step(2, 1, 0, 1, 1, "R7");
        lock_grp = '0;
        step(2, 0, 0, 0, 1, "R7");
        // Sweep every lock mask with a pseudo-random access stream (R4 under locks)
        for (int m = 0; m < 16; m++) begin
            lock_grp = 4'(m);
            for (int k = 0; k < 60; k++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                step(int'(lfsr[1:0]), lfsr[2], lfsr[3], int'(lfsr[6:4]), lfsr[7] | lfsr[8],
                     (m == 0) ? "R3" : "R4");
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule